// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Interlock for a Synchronous Buck Stage

This block decides, clock by clock, whether the high-side and low-side switch enables of a synchronous buck power stage may be on. A PWM request says which switch should conduct. Before the block hands conduction from one switch to the other, it first turns the conducting switch off. It then waits until a sense flag from the outgoing side confirms turn-off. For the high side, that flag says the low-side gate drive has fallen below a low threshold. For the low side, it says the switch node has fallen below a low threshold. The flag must hold for a programmable number of consecutive clock edges. So the dead time follows the real switching behaviour of the stage, with a minimum set in cycles.

On top of this sequencing sit three forced states, in a fixed priority. A latched overvoltage fault holds the low side on and the high side off until reset. A latched undervoltage fault turns both enables off, which leaves the stage tri-stated, until reset. An active undervoltage lockout holds the low side on while the lockout lasts. If a sense flag never confirms, the pending switch simply stays off. Both outputs are registered.

Top module: `buck_gate_interlock`

## Requirements
- R1: `hs_en` and `ls_en` are never 1 in the same cycle.
- R2: With `pwm_req`=1 and no override, `hs_en` rises only at the edge where `lsg_low` has been sampled 1 for `DT_CYC` consecutive edges while the block waits for the high side. Waiting starts at the edge that turns `ls_en` off. A 0 on `lsg_low` restarts the count.
- R3: With `pwm_req`=0 and no override, `ls_en` rises only at the edge where `swn_low` has been sampled 1 for `DT_CYC` consecutive edges while the block waits for the low side. A 0 on `swn_low` restarts the count.
- R4: If the confirming flag stays 0, the pending enable stays 0 for as long as the flag stays 0, with no timeout.
- R5: If `pwm_req` flips while the block waits, it switches to waiting for the other side and starts a fresh count.
- R6: While `uvlo`=1, with no fault, the outputs after each edge are `ls_en`=1 and `hs_en`=0, whatever `pwm_req` is. After release, normal sequencing resumes from the low-side-on state.
- R7: A 1 on `ov_fault` at an edge gives `ls_en`=1 and `hs_en`=0 from that edge until `rst`. This has priority over every other input.
- R8: A 1 on `uv_fault` at an edge, when no overvoltage fault is present or latched, gives both enables 0 from that edge until `rst`. This takes priority over `uvlo` and `pwm_req`.
- R9: While `rst`=1, both enables are 0. The first edge after reset leaves both off and starts the wait for the side that `pwm_req` selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the fault latches |
| pwm_req | input | 1 | 1 requests high-side conduction, 0 requests low-side conduction |
| lsg_low | input | 1 | Low-side gate drive is below the turn-off threshold |
| swn_low | input | 1 | Switch node is below the low threshold (high side is off) |
| uvlo | input | 1 | Supply undervoltage lockout active |
| ov_fault | input | 1 | Overvoltage fault command, latched |
| uv_fault | input | 1 | Undervoltage fault command, latched |
| hs_en | output | 1 | High-side switch enable, registered |
| ls_en | output | 1 | Low-side switch enable, registered |

## Verification
The handover is driven in several ways. In one, the sense flag confirms at once. In another it stays low for many cycles. In a third it drops for one cycle partway through the count. In the last, the PWM request reverses before the count ends. Together these separate a fixed-delay design from one that is truly feedback-gated, and they show whether the count restarts. Lockout is applied while the high side is on and then released with a high-side request, to show both the forced clamp and the clean return to sequencing. The faults are applied in both orders, and together with lockout, to check that each one latches and to check the order of priority.

// File: rtl/buck_gate_interlock_pkg.sv
package buck_gate_interlock_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_LS      = 3'd1,
    ST_WAIT_HS = 3'd2,
    ST_HS      = 3'd3,
    ST_WAIT_LS = 3'd4,
    ST_CLAMP   = 3'd5,
    ST_TRI     = 3'd6
  } ilk_state_e;

  localparam int SIDE_HS = 0;
  localparam int SIDE_LS = 1;
  localparam int NUM_SIDES = 2;

endpackage

// File: rtl/confirm_timer.sv
// Counts consecutive cycles of a sense flag while armed; done marks the
// edge on which the required run length is reached.
module confirm_timer #(
  parameter int DT_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic sense,
  output logic done
);
  localparam int CW = (DT_CYC > 1) ? $clog2(DT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm || !sense) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = arm & sense & (cnt == LAST);
endmodule

// File: rtl/flag_latch.sv
// Sticky fault flags: force is the live command OR the held value.
module flag_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cmd,
  output logic [N-1:0] force_o
);
  logic [N-1:0] held;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        held[i] <= 1'b0;
      end else if (cmd[i]) begin
        held[i] <= 1'b1;
      end
    end
    assign force_o[i] = cmd[i] | held[i];
  end
endmodule

// File: rtl/interlock_fsm.sv
module interlock_fsm
  import buck_gate_interlock_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwm_req,
  input  logic       uvlo,
  input  logic       ov_force,
  input  logic       uv_force,
  input  logic       done_hs,
  input  logic       done_ls,
  output ilk_state_e state,
  output logic       hs_en,
  output logic       ls_en
);
  ilk_state_e nxt;

  always_comb begin
    nxt = state;
    if (ov_force) begin
      nxt = ST_CLAMP;
    end else if (uv_force) begin
      nxt = ST_TRI;
    end else if (uvlo) begin
      nxt = ST_LS;
    end else begin
      unique case (state)
        ST_OFF:     nxt = pwm_req ? ST_WAIT_HS : ST_WAIT_LS;
        ST_LS:      if (pwm_req) nxt = ST_WAIT_HS;
        ST_WAIT_HS: if (!pwm_req) nxt = ST_WAIT_LS;
                    else if (done_hs) nxt = ST_HS;
        ST_HS:      if (!pwm_req) nxt = ST_WAIT_LS;
        ST_WAIT_LS: if (pwm_req) nxt = ST_WAIT_HS;
                    else if (done_ls) nxt = ST_LS;
        ST_CLAMP:   nxt = ST_CLAMP;
        ST_TRI:     nxt = ST_TRI;
        default:    nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OFF;
      hs_en <= 1'b0;
      ls_en <= 1'b0;
    end else begin
      state <= nxt;
      hs_en <= (nxt == ST_HS);
      ls_en <= (nxt == ST_LS) || (nxt == ST_CLAMP);
    end
  end
endmodule

// File: rtl/buck_gate_interlock.sv
module buck_gate_interlock
  import buck_gate_interlock_pkg::*;
#(
  parameter int DT_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_req,
  input  logic lsg_low,
  input  logic swn_low,
  input  logic uvlo,
  input  logic ov_fault,
  input  logic uv_fault,
  output logic hs_en,
  output logic ls_en
);
  ilk_state_e           state;
  logic [NUM_SIDES-1:0] arm, sense, done;
  logic [1:0]           force_v;

  assign arm[SIDE_HS]   = (state == ST_WAIT_HS);
  assign arm[SIDE_LS]   = (state == ST_WAIT_LS);
  assign sense[SIDE_HS] = lsg_low;
  assign sense[SIDE_LS] = swn_low;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    confirm_timer #(.DT_CYC(DT_CYC)) timer_i (
      .clk  (clk),
      .rst  (rst),
      .arm  (arm[s]),
      .sense(sense[s]),
      .done (done[s])
    );
  end

  flag_latch #(.N(2)) faults_i (
    .clk    (clk),
    .rst    (rst),
    .cmd    ({uv_fault, ov_fault}),
    .force_o(force_v)
  );

  interlock_fsm fsm_i (
    .clk     (clk),
    .rst     (rst),
    .pwm_req (pwm_req),
    .uvlo    (uvlo),
    .ov_force(force_v[0]),
    .uv_force(force_v[1]),
    .done_hs (done[SIDE_HS]),
    .done_ls (done[SIDE_LS]),
    .state   (state),
    .hs_en   (hs_en),
    .ls_en   (ls_en)
  );
endmodule

// File: rtl/buck_gate_interlock_chk.sv
module buck_gate_interlock_chk #(
  parameter int DT_CYC = 3
) (
  input logic clk,
  input logic rst,
  input logic pwm_req,
  input logic lsg_low,
  input logic swn_low,
  input logic uvlo,
  input logic ov_fault,
  input logic uv_fault,
  input logic hs_en,
  input logic ls_en
);
  localparam int RW = $clog2(DT_CYC + 1) + 1;

  logic [RW-1:0] lsg_run, swn_run;
  logic ov_seen, uv_seen, rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      lsg_run <= '0;
      swn_run <= '0;
      ov_seen <= 1'b0;
      uv_seen <= 1'b0;
    end else begin
      lsg_run <= !lsg_low ? '0 : (int'(lsg_run) < DT_CYC ? lsg_run + 1'b1 : lsg_run);
      swn_run <= !swn_low ? '0 : (int'(swn_run) < DT_CYC ? swn_run + 1'b1 : swn_run);
      if (ov_fault) ov_seen <= 1'b1;
      if (uv_fault) uv_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_q) begin
      p_reset_off_r9: assert (!hs_en && !ls_en) else $error("R9 enables on after reset");
    end
  end

  p_no_overlap_r1: assert property (@(posedge clk) disable iff (rst)
    !(hs_en && ls_en));

  p_hs_confirm_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en) |-> (int'(lsg_run) >= DT_CYC));

  p_ls_confirm_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_en) |-> ($past(uvlo) || $past(ov_fault) || int'(swn_run) >= DT_CYC));

  p_hs_held_r4: assert property (@(posedge clk) disable iff (rst)
    (!lsg_low && !hs_en) |=> !hs_en);

  p_lockout_r6: assert property (@(posedge clk) disable iff (rst)
    (uvlo && !ov_fault && !ov_seen && !uv_fault && !uv_seen) |=> (ls_en && !hs_en));

  p_ov_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    (ov_fault || ov_seen) |=> (ls_en && !hs_en));

  p_uv_tristate_r8: assert property (@(posedge clk) disable iff (rst)
    ((uv_fault || uv_seen) && !ov_fault && !ov_seen) |=> (!ls_en && !hs_en));
endmodule

bind buck_gate_interlock buck_gate_interlock_chk #(.DT_CYC(DT_CYC)) chk_i (
  .clk(clk), .rst(rst), .pwm_req(pwm_req), .lsg_low(lsg_low), .swn_low(swn_low),
  .uvlo(uvlo), .ov_fault(ov_fault), .uv_fault(uv_fault), .hs_en(hs_en), .ls_en(ls_en)
);

// File: tb/buck_gate_interlock_tb_top.sv
module buck_gate_interlock_tb_top;
  localparam int DT = 3;

  logic clk = 1'b0;
  logic rst, pwm_req, lsg_low, swn_low, uvlo, ov_fault, uv_fault;
  logic hs_en, ls_en;

  typedef struct {
    logic  hs;
    logic  ls;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   n_run  = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  buck_gate_interlock #(.DT_CYC(DT)) dut_i (
    .clk(clk), .rst(rst), .pwm_req(pwm_req), .lsg_low(lsg_low), .swn_low(swn_low),
    .uvlo(uvlo), .ov_fault(ov_fault), .uv_fault(uv_fault), .hs_en(hs_en), .ls_en(ls_en)
  );

  // Driver: apply one cycle of stimulus and the outputs expected after the edge.
  task automatic d(input logic r, p, l, s, u, ov, uv, ehs, els, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; pwm_req = p; lsg_low = l; swn_low = s;
    uvlo = u; ov_fault = ov; uv_fault = uv;
    e.hs = ehs; e.ls = els; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare just after each edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      cur = q.pop_front();
      n_run++;
      if (hs_en !== cur.hs || ls_en !== cur.ls) begin
        n_fail++;
        $display("FAIL %s: got hs=%b ls=%b expected hs=%b ls=%b at %0t",
                 cur.tag, hs_en, ls_en, cur.hs, cur.ls, $time);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset holds both off, first edge after reset starts the low-side wait
    d(1,0,0,0,0,0,0, 0,0,"R9");
    d(1,0,0,1,0,0,0, 0,0,"R9");
    d(0,0,0,1,0,0,0, 0,0,"R9");
    // R3: low side rises on the DT-th edge of confirmed switch node
    d(0,0,0,1,0,0,0, 0,0,"R3");
    d(0,0,0,1,0,0,0, 0,0,"R3");
    d(0,0,0,1,0,0,0, 0,1,"R3");
    d(0,0,0,1,0,0,0, 0,1,"R3");
    // R1: request high side, low side drops first
    d(0,1,0,1,0,0,0, 0,0,"R1");
    // R4: low-side gate never confirms, high side stays off
    for (int i = 0; i < 6; i++) d(0,1,0,1,0,0,0, 0,0,"R4");
    // R2: confirmation arrives, high side after DT edges
    d(0,1,1,1,0,0,0, 0,0,"R2");
    d(0,1,1,1,0,0,0, 0,0,"R2");
    d(0,1,1,1,0,0,0, 1,0,"R2");
    d(0,1,1,1,0,0,0, 1,0,"R2");
    // R1/R4: back to low side, node still high
    d(0,0,1,0,0,0,0, 0,0,"R1");
    d(0,0,1,0,0,0,0, 0,0,"R4");
    d(0,0,1,0,0,0,0, 0,0,"R4");
    // R3: one-cycle drop of the node flag restarts the count
    d(0,0,1,1,0,0,0, 0,0,"R3");
    d(0,0,1,1,0,0,0, 0,0,"R3");
    d(0,0,1,0,0,0,0, 0,0,"R3");
    d(0,0,1,1,0,0,0, 0,0,"R3");
    d(0,0,1,1,0,0,0, 0,0,"R3");
    d(0,0,1,1,0,0,0, 0,1,"R3");
    // R5: request reverses during the high-side wait
    d(0,1,1,1,0,0,0, 0,0,"R5");
    d(0,1,1,1,0,0,0, 0,0,"R5");
    d(0,0,1,1,0,0,0, 0,0,"R5");
    d(0,0,1,1,0,0,0, 0,0,"R5");
    d(0,0,1,1,0,0,0, 0,0,"R5");
    d(0,0,1,1,0,0,0, 0,1,"R5");
    // R2: from low side with immediate confirmation
    d(0,1,1,1,0,0,0, 0,0,"R2");
    d(0,1,1,1,0,0,0, 0,0,"R2");
    d(0,1,1,1,0,0,0, 0,0,"R2");
    d(0,1,1,1,0,0,0, 1,0,"R2");
    // R6: lockout while high side on, overrides the request
    d(0,1,1,1,1,0,0, 0,1,"R6");
    d(0,1,1,1,1,0,0, 0,1,"R6");
    // R6: release resumes sequencing from low side on
    d(0,1,1,1,0,0,0, 0,0,"R6");
    d(0,1,1,1,0,0,0, 0,0,"R6");
    d(0,1,1,1,0,0,0, 0,0,"R6");
    d(0,1,1,1,0,0,0, 1,0,"R6");
    // R7: overvoltage pulse latches the clamp
    d(0,1,1,1,0,1,0, 0,1,"R7");
    for (int i = 0; i < 3; i++) d(0,1,1,1,0,0,0, 0,1,"R7");
    d(0,0,1,1,0,0,1, 0,1,"R7");
    d(0,1,1,1,1,0,0, 0,1,"R7");
    // R9: reset clears the latch
    d(1,0,0,1,0,0,0, 0,0,"R9");
    d(0,0,0,1,0,0,0, 0,0,"R9");
    d(0,0,0,1,0,0,0, 0,0,"R3");
    d(0,0,0,1,0,0,0, 0,0,"R3");
    d(0,0,0,1,0,0,0, 0,1,"R3");
    // R8: undervoltage pulse latches tri-state
    d(0,0,0,1,0,0,1, 0,0,"R8");
    for (int i = 0; i < 4; i++) d(0,1,1,1,0,0,0, 0,0,"R8");
    for (int i = 0; i < 4; i++) d(0,0,1,1,0,0,0, 0,0,"R8");
    d(0,0,1,1,1,0,0, 0,0,"R8");
    // R7: overvoltage outranks a latched undervoltage
    d(0,0,1,1,0,1,0, 0,1,"R7");
    d(0,0,1,1,0,0,0, 0,1,"R7");
    // R7: same-edge overvoltage and undervoltage after reset
    d(1,0,0,0,0,0,0, 0,0,"R9");
    d(0,1,1,1,1,1,1, 0,1,"R7");
    d(0,1,1,1,0,0,0, 0,1,"R7");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule